// File: doc/BRIEF.md
# Power-Down Sequencer with Wake Interrupt

This block takes a microcontroller into a low-power state and brings it back. Software writes a control register with its top bit set to request power-down. After a short, fixed count of CPU clock cycles the block raises a power-down output that switches the analog circuits off: the reference, the PLL/VCO and the bias currents. Software must issue its stop instruction before that count runs out.

A wake event ends the power-down state. The wake inputs come from sources such as a real-time clock, a keypad, a card-detect line or a USB resume. The event clears both the request bit and the power-down output. A longer fixed count then gives the oscillator and PLL time to settle. When it expires, the block raises a level-held wake interrupt on the CPU's external interrupt 0 line, which brings the CPU out of its stop state.

The same register holds two more fields. One is a mask with one enable bit for each wake source. The other is a source code that can route a general-purpose pin onto interrupt 0 as an active-high or an active-low request.

Top module: `pwrdn_sequencer`

## Requirements
- R1: A register write with bit 7 = 1 from the idle state accepts a power-down request. The read-back bit 7 (`ctrl_rdata[7]`) is 1 from the cycle after the write edge. The same write clears any pending wake interrupt. Bits [6:0] of every write are stored and read back on `ctrl_rdata[6:0]`.
- R2: `pd_out` rises exactly 32 clock cycles after the write edge that accepted the request.
- R3: A write with bit 7 = 0 before those 32 cycles have elapsed aborts the request. `ctrl_rdata[7]` returns to 0 and `pd_out` never asserts.
- R4: While `pd_out` is high, bit 7 of a write has no effect. `pd_out` and `ctrl_rdata[7]` stay high until a wake event arrives.
- R5: An enabled wake input that goes high while `pd_out` is high passes through two synchronizer flops. On the third rising edge after the input changes, the block clears `pd_out` and `ctrl_rdata[7]`.
- R6: `wake_irq` rises exactly 512 clock cycles after the edge that cleared `pd_out`.
- R7: `wake_irq` stays high until a register write acknowledges it. That write clears it on its write edge.
- R8: Wake inputs are ignored while `pd_out` is low. They start no settling count and raise no interrupt.
- R9: A request write (bit 7 = 1) that arrives during the 512-cycle settling count is ignored. `ctrl_rdata[7]` stays 0 and the interrupt still arrives at its normal time.
- R10: Register bits [3:0] enable the four wake inputs one per bit, with bit n enabling `wake_in[n]`. A wake input whose enable bit is 0 does not end power-down.
- R11: `int0_out` is `wake_irq` ORed with the routed pin. Source code 4 in bits [6:4] routes `gp_pin` active-high, code 6 routes it active-low, and any other code routes nothing.
- R12: A synchronous active-low reset clears the state, both counters, the stored register bits and `wake_irq`.
- R13: Once the interrupt is pending, a new request starts the whole sequence again with the same 32-cycle and 512-cycle timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; clocks all state |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Register write strobe, one cycle per write |
| ctrl_wdata | input | 8 | Write data: [7] request, [6:4] INT0 source code, [3:0] wake enables |
| ctrl_rdata | output | 8 | Read-back: [7] live request state, [6:0] stored bits |
| wake_in | input | 4 | Asynchronous wake-event inputs |
| gp_pin | input | 1 | General-purpose pin that can be routed to interrupt 0 |
| pd_out | output | 1 | Power-down: high turns the analog functions off |
| wake_irq | output | 1 | Level-held interrupt raised after the settling count |
| int0_out | output | 1 | External interrupt 0 to the CPU |

## Verification
The hardest situations to reach are the ones where an input arrives in a phase where it must do nothing. Examples are a request write during the 512-cycle settling window, a bit-7 clear while already powered down, and a masked wake source while powered down. The stimulus reaches each phase by counting cycles from the write edge or the wake edge that started it. It then applies the stray input at a chosen offset inside that window and checks the outputs at a later, computed cycle. The cycle of every edge on `pd_out` and `wake_irq` is predicted from the synchronizer depth and the two terminal counts, and the outputs are compared at exactly those cycles.

// File: rtl/pds_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes an 8-bit control register with the field layout listed below.
package pds_pkg;
    localparam int CTRL_W   = 8;
    localparam int REQ_POS  = 7;   // power-down request bit
    localparam int SRC_LSB  = 4;   // interrupt-0 source code field
    localparam int SRC_W    = 3;
    localparam int MASK_W   = 4;   // one enable per wake input
    localparam logic [SRC_W-1:0] SRC_PIN_HIGH = 3'd4;
    localparam logic [SRC_W-1:0] SRC_PIN_LOW  = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM    = 2'd1,
        ST_DOWN   = 2'd2,
        ST_SETTLE = 2'd3
    } pds_state_e;
endpackage

// File: rtl/pds_sync.sv
// Module: multi-bit synchronizer, one independent flop chain per bit.
// Assumes each bit is an unrelated level; no bus coherency is implied.
module pds_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // shift the raw level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[b]};
        end

        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pds_tc_counter.sv
// Module: up-counter with count enable, synchronous clear and terminal count.
// Assumes clear has priority over enable; tc is high in the enabled cycle
// that would wrap the counter.
module pds_tc_counter #(
    parameter int WIDTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic clr,
    output logic tc
);
    logic [WIDTH-1:0] count;

    // advance while enabled, return to zero on clear
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (ce)  count <= count + 1'b1;
    end

    assign tc = ce & (&count);
endmodule

// File: rtl/pds_int0_route.sv
// Module: forms interrupt 0 from the wake interrupt and an optionally
// routed general-purpose pin. Assumes the source code is stable software state.
module pds_int0_route
    import pds_pkg::*;
(
    input  logic             wake_irq,
    input  logic             pin,
    input  logic [SRC_W-1:0] src_code,
    output logic             int0
);
    logic pin_req;

    // pick the pin polarity selected by the source code
    always_comb begin
        case (src_code)
            SRC_PIN_HIGH: pin_req = pin;
            SRC_PIN_LOW:  pin_req = ~pin;
            default:      pin_req = 1'b0;
        endcase
    end

    assign int0 = wake_irq | pin_req;
endmodule

// File: rtl/pwrdn_sequencer.sv
// Module: power-down sequencer. A request write arms a short pre-shutdown
// count; its terminal count raises pd_out. An enabled, synchronized wake
// input while powered down clears pd_out and starts a long settling count;
// its terminal count raises a level-held wake interrupt.
// Assumes a single clock domain (the CPU clock) and asynchronous wake inputs.
module pwrdn_sequencer
    import pds_pkg::*;
#(
    parameter int PRE_W       = 5,
    parameter int POST_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic [MASK_W-1:0] wake_in,
    input  logic              gp_pin,
    output logic              pd_out,
    output logic              wake_irq,
    output logic              int0_out
);
    localparam int CFG_W = CTRL_W - 1;

    pds_state_e        state, state_nx;
    logic [CFG_W-1:0]  cfg;
    logic [MASK_W-1:0] wake_sync;
    logic              wake_hit;
    logic              pre_tc, post_tc;
    logic              req_wr_set, req_wr_clr;

    pds_sync #(.WIDTH(MASK_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_in),
        .sync_out (wake_sync)
    );

    pds_tc_counter #(.WIDTH(PRE_W)) u_pre_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (state == ST_ARM),
        .clr   (state != ST_ARM),
        .tc    (pre_tc)
    );

    pds_tc_counter #(.WIDTH(POST_W)) u_post_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (state == ST_SETTLE),
        .clr   (state != ST_SETTLE),
        .tc    (post_tc)
    );

    assign req_wr_set = ctrl_wr &  ctrl_wdata[REQ_POS];
    assign req_wr_clr = ctrl_wr & ~ctrl_wdata[REQ_POS];
    assign wake_hit   = (state == ST_DOWN) & |(wake_sync & cfg[MASK_W-1:0]);

    // next-state decision for the four-phase sequence
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (req_wr_set) state_nx = ST_ARM;
            ST_ARM:    if (req_wr_clr) state_nx = ST_IDLE;
                       else if (pre_tc) state_nx = ST_DOWN;
            ST_DOWN:   if (wake_hit) state_nx = ST_SETTLE;
            ST_SETTLE: if (post_tc) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // stored register fields: wake enables and interrupt-0 source code
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg <= '0;
        else if (ctrl_wr) cfg <= ctrl_wdata[CFG_W-1:0];
    end

    // wake interrupt: set by settling terminal count, cleared by any write
    always_ff @(posedge clk) begin
        if (!rst_n)       wake_irq <= 1'b0;
        else if (post_tc) wake_irq <= 1'b1;
        else if (ctrl_wr) wake_irq <= 1'b0;
    end

    assign pd_out     = (state == ST_DOWN);
    assign ctrl_rdata = {(state == ST_ARM) || (state == ST_DOWN), cfg};

    pds_int0_route u_route (
        .wake_irq (wake_irq),
        .pin      (gp_pin),
        .src_code (cfg[SRC_LSB +: SRC_W]),
        .int0     (int0_out)
    );

    // R2
    pd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_out) |-> $past(pre_tc));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> $past(post_tc));

    // R4
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_out && !wake_hit) |=> pd_out);

    // R5
    pd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_out) |-> (!ctrl_rdata[REQ_POS] && $past(wake_hit)));

    // R8
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_SETTLE));

    // R3
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && req_wr_clr) |=> !pd_out);
endmodule

// File: tb/pwrdn_sequencer_bench.sv
`timescale 1ns/1ps
module pwrdn_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic [3:0] wake_in = 4'h0;
    logic       gp_pin = 1'b0;
    logic       pd_out, wake_irq, int0_out;

    int cyc = 0;
    int errors = 0;
    int checks = 0;

    typedef struct {
        int    at;
        int    sig;   // 0 pd_out, 1 wake_irq, 2 request bit, 3 int0_out
        logic  val;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    pwrdn_sequencer u_pwrdn_sequencer (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .wake_in(wake_in), .gp_pin(gp_pin),
        .pd_out(pd_out), .wake_irq(wake_irq), .int0_out(int0_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic pick(int sig);
        case (sig)
            0: return pd_out;
            1: return wake_irq;
            2: return ctrl_rdata[7];
            default: return int0_out;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic expect_at(int at, int sig, logic val, string req);
        exp_t e;
        e.at = at; e.sig = sig; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: pop and compare every item due in the current cycle
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < sb.size()) begin
            if (sb[i].at == cyc) begin
                check($sformatf("%s sig%0d", sb[i].req, sb[i].sig),
                      {7'd0, pick(sb[i].sig)}, {7'd0, sb[i].val});
                sb.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic wait_to(int at);
        while (cyc < at) @(negedge clk);
    endtask

    // one-cycle register write, starting and ending at a falling edge
    task automatic wr(logic [7:0] d, output int c);
        c = cyc;
        ctrl_wr = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c, c2, c3, d, e, f, g, r, s, h, cw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        check("R12 pd", {7'd0, pd_out}, 8'h00);
        check("R12 irq", {7'd0, wake_irq}, 8'h00);
        check("R12 rdata", ctrl_rdata, 8'h00);

        // Scenario A: full sequence
        wr(8'h8F, c);
        expect_at(c + 1, 2, 1'b1, "R1");
        expect_at(c + 32, 0, 1'b0, "R2");
        expect_at(c + 33, 0, 1'b1, "R2");
        check("R1 stored", ctrl_rdata, 8'h8F);
        wait_to(c + 40);
        wr(8'h0F, c2);                       // R4 clear attempt while down
        expect_at(c2 + 1, 0, 1'b1, "R4");
        expect_at(c2 + 1, 2, 1'b1, "R4");
        expect_at(c2 + 5, 0, 1'b1, "R4");
        wait_to(c2 + 6);
        d = cyc; wake_in = 4'b0001;
        expect_at(d + 2, 0, 1'b1, "R5");
        expect_at(d + 3, 0, 1'b0, "R5");
        expect_at(d + 3, 2, 1'b0, "R5");
        expect_at(d + 514, 1, 1'b0, "R6");
        expect_at(d + 515, 1, 1'b1, "R6");
        expect_at(d + 515, 3, 1'b1, "R11");
        wait_to(d + 10); wake_in = 4'b0000;
        wait_to(d + 100);
        wr(8'h8F, cw);                       // R9 request during settling
        expect_at(cw + 1, 2, 1'b0, "R9");
        expect_at(cw + 5, 0, 1'b0, "R9");
        wait_to(d + 700);
        expect_at(cyc + 1, 1, 1'b1, "R7");
        wait_to(d + 702);
        wr(8'h0F, c3);
        expect_at(c3 + 1, 1, 1'b0, "R7");
        expect_at(c3 + 1, 3, 1'b0, "R7");
        wait_to(c3 + 5);

        // Scenario B: abort before the short count ends
        wr(8'h8F, c);
        wait_to(c + 10);
        wr(8'h0F, c2);
        expect_at(c2 + 1, 2, 1'b0, "R3");
        expect_at(c + 33, 0, 1'b0, "R3");
        expect_at(c + 40, 0, 1'b0, "R3");
        wait_to(c + 45);

        // Scenario C: wake while not powered down
        e = cyc; wake_in = 4'b1111;
        wait_to(e + 5); wake_in = 4'b0000;
        expect_at(e + 520, 1, 1'b0, "R8");
        expect_at(e + 520, 0, 1'b0, "R8");
        expect_at(e + 520, 2, 1'b0, "R8");
        wait_to(e + 525);

        // Scenario D: masked source, then enabled source, then rearm
        wr(8'h8E, c);
        expect_at(c + 33, 0, 1'b1, "R10");
        wait_to(c + 35);
        f = cyc; wake_in = 4'b0001;
        expect_at(f + 6, 0, 1'b1, "R10");
        wait_to(f + 7); wake_in = 4'b0000;
        wait_to(f + 10);
        g = cyc; wake_in = 4'b0010;
        expect_at(g + 3, 0, 1'b0, "R10");
        expect_at(g + 515, 1, 1'b1, "R13");
        wait_to(g + 5); wake_in = 4'b0000;
        wait_to(g + 520);
        wr(8'h8F, r);
        expect_at(r + 1, 1, 1'b0, "R13");
        expect_at(r + 1, 2, 1'b1, "R13");
        expect_at(r + 32, 0, 1'b0, "R13");
        expect_at(r + 33, 0, 1'b1, "R13");
        wait_to(r + 40);
        s = cyc; wake_in = 4'b0100;
        expect_at(s + 3, 0, 1'b0, "R13");
        expect_at(s + 514, 1, 1'b0, "R13");
        expect_at(s + 515, 1, 1'b1, "R13");
        wait_to(s + 5); wake_in = 4'b0000;
        wait_to(s + 520);

        // R12 reset with interrupt pending
        h = cyc; rst_n = 1'b0;
        expect_at(h + 1, 1, 1'b0, "R12");
        expect_at(h + 1, 0, 1'b0, "R12");
        expect_at(h + 1, 2, 1'b0, "R12");
        wait_to(h + 2);
        check("R12 rdata", ctrl_rdata, 8'h00);
        wait_to(h + 3); rst_n = 1'b1;

        // Scenario E: interrupt-0 pin routing
        wr(8'h4F, c);
        gp_pin = 1'b1; #0.5;
        check("R11 code4 pin1", {7'd0, int0_out}, 8'h01);
        gp_pin = 1'b0; #0.5;
        check("R11 code4 pin0", {7'd0, int0_out}, 8'h00);
        wait_to(cyc + 1);
        wr(8'h6F, c);
        check("R1 stored", ctrl_rdata, 8'h6F);
        check("R11 code6 pin0", {7'd0, int0_out}, 8'h01);
        gp_pin = 1'b1; #0.5;
        check("R11 code6 pin1", {7'd0, int0_out}, 8'h00);
        wait_to(cyc + 1);
        wr(8'h5F, c);
        check("R11 code5 pin1", {7'd0, int0_out}, 8'h00);
        gp_pin = 1'b0; #0.5;
        check("R11 code5 pin0", {7'd0, int0_out}, 8'h00);

        wait_to(cyc + 3);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual=%0d expected=0 items left", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule